// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes five active-low interrupt pins from outside the chip and turns them into clean, clock-domain requests for the core. One pin is non-maskable. The other four are maskable request lines. Each pin is retimed by two flip-flops clocked on the falling clock edge. An interrupt is accepted only when three consecutive retimed samples read high, low, low. An accepted event sets a per-source pending bit. The bit stays set until the core acknowledges it.

The pending bits of the maskable lines are gated by an enable mask. The non-maskable source is never gated. A priority encoder reports the lowest-numbered pending, enabled source. While the core is in a clock-stopped idle state, a low level on any pin raises a wake request through a path that needs no clock edge. The request stays up until the core leaves idle.

Top module: `xirq_conditioner`

## Requirements
- R1: A pin that falls and stays low shows its pending bit on the third rising clock edge after the pin falls, and not on the second.
- R2: A low level that covers exactly two falling-edge samples, with high samples before and after it, is accepted as an event. A low level that covers a single falling-edge sample produces no event.
- R3: All retiming stages reset to the high (inactive) level. A pin that is low when reset is released produces no event until it has been sampled high at least once.
- R4: A pin held low without a break produces exactly one event. After that event is acknowledged, its pending bit stays clear for as long as the pin stays low.
- R5: A pending bit set by an event stays set until its acknowledge bit (`irq_ack`, same bit position) is high at a rising edge. The bit then reads clear after that edge.
- R6: When an acknowledge and a new event for the same source meet at the same rising edge, the pending bit stays set.
- R7: Source k (k = 1..4) counts for the request only while `irq_mask_en[k-1]` is 1. Its pending bit is recorded regardless of the mask.
- R8: `irq_index` is the lowest-numbered pending, enabled source. Code 0 is the non-maskable pin (`ext_irq_n[0]`), and codes 1..4 are `ext_irq_n[1]`..`ext_irq_n[4]`. The non-maskable pin ignores the mask. `irq_valid` is 0 and `irq_index` is 0 when no enabled source is pending.
- R9: While `idle_stop` is 1, any pin going low sets `wake_req` without any clock edge. `wake_req` then holds, even after the pin returns high, until a rising edge sees `idle_stop` at 0. A low pin while `idle_stop` is 0 does not raise `wake_req`.
- R10: During reset, `irq_pend`, `irq_valid`, `irq_index` and `wake_req` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; pins are sampled on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq_n | input | 5 | Active-low interrupt pins; bit 0 non-maskable, bits 1..4 maskable |
| irq_ack | input | 5 | One-cycle acknowledge per source, same bit order as the pins |
| irq_mask_en | input | 4 | Enable for maskable sources; bit j gates pin bit j+1 |
| idle_stop | input | 1 | Core is in a clock-stopped idle state |
| irq_pend | output | 5 | Pending flag per source |
| irq_valid | output | 1 | An enabled source is pending |
| irq_index | output | 3 | Code of the highest-priority enabled pending source |
| wake_req | output | 1 | Clockless wake request from idle |

## Verification
The pattern detector is driven with lows lasting one sample and two samples, with a long low, and with a pin already low at reset release. Together these separate true 1-0-0 acceptance from plain edge or level detection. A table then drives the pins while the mask patterns change. This shows that pending capture does not depend on the mask, that the non-maskable source wins, and that the priority runs from low to high index. Acknowledge timing is checked once on its own and once at the very edge where a fresh event lands. The wake path is exercised with the clock halted, to show that it needs no edge.

// File: rtl/xirq_pkg.sv
// Shared definitions for the external interrupt conditioner.
// Assumes nothing beyond elaboration-time constant evaluation.
package xirq_pkg;

    // Inactive level of an active-low pin, used as reset preset.
    localparam logic PIN_IDLE = 1'b1;

    // Width of an index able to code n sources (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/xirq_pin_detect.sv
// Retimes one active-low pin with two falling-edge flops and flags a
// 1-0-0 pattern over three consecutive retimed samples.
// Assumes: rst_n is synchronous and held for at least one falling edge.
// The output event is one clock period wide, launched from the falling edge.
module xirq_pin_detect
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic evt
);

    logic s1_q, s2_q, h1_q, h2_q;   // retime stages and sample history
    logic v1_q, v2_q;               // marks that s1/s2 hold real post-reset samples
    logic arm_q;                    // a genuine high sample has been seen

    // Retime the pin and shift the sample history on each falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            s1_q <= PIN_IDLE;
            s2_q <= PIN_IDLE;
            h1_q <= PIN_IDLE;
            h2_q <= PIN_IDLE;
        end else begin
            s1_q <= pin_n;
            s2_q <= s1_q;
            h1_q <= s2_q;
            h2_q <= h1_q;
        end
    end

    // Arm the detector once a real (not preset) high sample has been retimed.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            v1_q  <= 1'b0;
            v2_q  <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            v1_q  <= 1'b1;
            v2_q  <= v1_q;
            arm_q <= arm_q | (v2_q & s2_q);
        end
    end

    // Event when the oldest sample is high and the two newer ones are low.
    always_comb evt = arm_q & h2_q & ~h1_q & ~s2_q;

    // R4: a held low gives a single event cycle, never two in a row.
    a_r4_single_evt: assert property (@(negedge clk) disable iff (!rst_n)
        evt |=> !evt);

    // R3: once armed the detector stays armed until reset.
    a_r3_arm_sticky: assert property (@(negedge clk) disable iff (!rst_n)
        arm_q |=> arm_q);

endmodule

// File: rtl/xirq_pending.sv
// Holds one pending flag per source. An event sets the flag; an
// acknowledge clears it; an event wins when both arrive together.
// Assumes: evt_i comes from falling-edge logic and is stable at rising edges.
module xirq_pending #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] pend_o
);

    logic [NSRC-1:0] pend_q;

    // Update pending flags: set on event, clear on acknowledge, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_i) | evt_i;
    end

    always_comb pend_o = pend_q;

    // R5 / R6: every event seen at an edge is pending after it.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

    // R5: an acknowledge without a coincident event clears the flag.
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_i & ~evt_i)) |=> ((pend_q & $past(ack_i & ~evt_i)) == '0));

    // R5: with neither event nor acknowledge the flags do not move.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0 && ack_i == '0) |=> $stable(pend_q));

endmodule

// File: rtl/xirq_prio.sv
// Picks the lowest-numbered active source and reports its index.
// Assumes: bit 0 is the non-maskable source and so always wins.
module xirq_prio #(
    parameter int unsigned NSRC  = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  act_i,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top so the lowest active index is the one left.
    always_comb begin
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act_i[i]) idx_o = IDX_W'(i);
        end
        vld_o = |act_i;
    end

    // R8: a reported index always names an active source.
    a_r8_idx_active: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> act_i[idx_o]);

    // R8: the non-maskable source, when active, is the one reported.
    a_r8_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        act_i[0] |-> (vld_o && idx_o == '0));

    // R8: nothing active means no request and a zero index.
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == '0) |-> (!vld_o && idx_o == '0));

endmodule

// File: rtl/xirq_wake.sv
// Raises a wake request from clock-stopped idle on any low pin. The set
// path is asynchronous; clearing waits for a clock edge outside idle.
// Assumes: idle_i only changes while the clock runs.
module xirq_wake #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle_i,
    input  logic [NSRC-1:0] pin_n,
    output logic            wake_o
);

    logic any_low;
    logic wake_q;

    // Any pin low while idle forms the clockless set term.
    always_comb any_low = idle_i & ~(&pin_n);

    // Set asynchronously from a pin; clear on a clock edge outside idle.
    always_ff @(posedge clk or posedge any_low) begin
        if (any_low)      wake_q <= 1'b1;
        else if (!rst_n)  wake_q <= 1'b0;
        else if (!idle_i) wake_q <= 1'b0;
    end

    always_comb wake_o = wake_q;

    // R9: the request holds for as long as the core stays idle.
    a_r9_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_q && idle_i) |=> wake_q);

    // R9: no request while the core has been awake across an edge.
    a_r9_no_wake_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_i && $past(!idle_i)) |-> !wake_q);

endmodule

// File: rtl/xirq_conditioner.sv
// Top of the external interrupt conditioner. One pin detector per source,
// per-source pending flags, mask gating of maskable lines, a priority
// encoder and the clockless wake path.
// Assumes: ext_irq_n[0] is the non-maskable pin; bit j of irq_mask_en
// enables ext_irq_n[j+1].
module xirq_conditioner
    import xirq_pkg::*;
#(
    parameter  int unsigned NUM_MASK = 4,
    localparam int unsigned NSRC     = NUM_MASK + 1,
    localparam int unsigned IDX_W    = idx_bits(NSRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     ext_irq_n,
    input  logic [NSRC-1:0]     irq_ack,
    input  logic [NUM_MASK-1:0] irq_mask_en,
    input  logic                idle_stop,
    output logic [NSRC-1:0]     irq_pend,
    output logic                irq_valid,
    output logic [IDX_W-1:0]    irq_index,
    output logic                wake_req
);

    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] act;

    // One retime-and-detect slice per pin.
    for (genvar g = 0; g < NSRC; g++) begin : g_pin
        xirq_pin_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (ext_irq_n[g]),
            .evt   (evt[g])
        );
    end

    xirq_pending #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .ack_i  (irq_ack),
        .pend_o (pend)
    );

    // Gate maskable flags by their enables; the non-maskable bit passes.
    always_comb act = pend & {irq_mask_en, 1'b1};

    xirq_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .vld_o (irq_valid),
        .idx_o (irq_index)
    );

    xirq_wake #(.NSRC(NSRC)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle_i (idle_stop),
        .pin_n  (ext_irq_n),
        .wake_o (wake_req)
    );

    always_comb irq_pend = pend;

    // R7: a masked-off maskable source never produces a request by itself.
    a_r7_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] == 1'b0 && (pend[NSRC-1:1] & irq_mask_en) == '0) |-> !irq_valid);

endmodule

// File: tb/xirq_conditioner_tb.sv
module xirq_conditioner_tb;

    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n;
    logic [4:0] ext_irq_n;
    logic [4:0] irq_ack;
    logic [3:0] irq_mask_en;
    logic       idle_stop;
    logic [4:0] irq_pend;
    logic       irq_valid;
    logic [2:0] irq_index;
    logic       wake_req;

    int total = 0;
    int bad   = 0;

    xirq_conditioner u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_irq_n   (ext_irq_n),
        .irq_ack     (irq_ack),
        .irq_mask_en (irq_mask_en),
        .idle_stop   (idle_stop),
        .irq_pend    (irq_pend),
        .irq_valid   (irq_valid),
        .irq_index   (irq_index),
        .wake_req    (wake_req)
    );

    // 250 MHz clock that the bench can halt.
    always begin
        #2;
        if (clk_run) clk = ~clk;
    end

    typedef struct packed {
        logic [4:0] pins;
        logic [3:0] mask;
        logic [4:0] pend;
        logic       vld;
        logic [2:0] idx;
    } vec_t;

    // Each row is held for four cycles, then the outputs are compared.
    localparam vec_t VEC [8] = '{
        '{5'b11111, 4'b0000, 5'b00000, 1'b0, 3'd0},
        '{5'b11101, 4'b0000, 5'b00010, 1'b0, 3'd0},
        '{5'b11101, 4'b0001, 5'b00010, 1'b1, 3'd1},
        '{5'b10101, 4'b0001, 5'b01010, 1'b1, 3'd1},
        '{5'b10101, 4'b0100, 5'b01010, 1'b1, 3'd3},
        '{5'b10100, 4'b0000, 5'b01011, 1'b1, 3'd0},
        '{5'b11111, 4'b1111, 5'b01011, 1'b1, 3'd0},
        '{5'b01111, 4'b1000, 5'b11011, 1'b1, 3'd0}
    };

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ext_irq_n = '1; irq_ack = '0; irq_mask_en = '0; idle_stop = 1'b0;
        step(4);
        // R10: reset state
        chk("R10 pend", irq_pend, 0);
        chk("R10 valid", irq_valid, 0);
        chk("R10 index", irq_index, 0);
        chk("R10 wake", wake_req, 0);
        rst_n = 1'b1;
        step(6);

        // R7 / R8: table of pin and mask patterns
        for (int i = 0; i < 8; i++) begin
            ext_irq_n   = VEC[i].pins;
            irq_mask_en = VEC[i].mask;
            step(4);
            chk($sformatf("R7 row%0d pend", i), irq_pend, VEC[i].pend);
            chk($sformatf("R8 row%0d valid", i), irq_valid, VEC[i].vld);
            chk($sformatf("R8 row%0d index", i), irq_index, VEC[i].idx);
        end

        // R5: acknowledge clears pin 4 flag after one edge
        irq_ack = 5'b10000; step(1); irq_ack = '0;
        chk("R5 ack clears", irq_pend, 5'b01011);
        // R4: pin 4 still low, no second event
        step(6);
        chk("R4 held low one event", irq_pend, 5'b01011);

        // R6: acknowledge meets a fresh event at the same edge
        ext_irq_n = 5'b11111; step(3);
        ext_irq_n = 5'b01111; step(2);
        irq_ack = 5'b10000; step(1); irq_ack = '0;
        chk("R6 set wins", irq_pend[4], 1);
        irq_ack = 5'b11111; step(1); irq_ack = '0;
        chk("R5 ack all", irq_pend, 0);
        chk("R8 none valid", irq_valid, 0);
        chk("R8 none index", irq_index, 0);
        ext_irq_n = 5'b11111; step(4);

        // R2: one-sample low is rejected
        ext_irq_n[2] = 1'b0; step(1); ext_irq_n[2] = 1'b1; step(5);
        chk("R2 single sample", irq_pend[2], 0);
        // R2: two-sample low is accepted
        ext_irq_n[2] = 1'b0; step(2); ext_irq_n[2] = 1'b1; step(5);
        chk("R2 two samples", irq_pend[2], 1);

        // R1: latency of three rising edges
        ext_irq_n[3] = 1'b0; step(2);
        chk("R1 not at edge 2", irq_pend[3], 0);
        step(1);
        chk("R1 at edge 3", irq_pend[3], 1);
        ext_irq_n[3] = 1'b1;

        // R3: pin low across reset release
        rst_n = 1'b0; ext_irq_n[1] = 1'b0; step(3);
        chk("R10 pend in reset", irq_pend, 0);
        rst_n = 1'b1; step(8);
        chk("R3 low at release", irq_pend[1], 0);
        ext_irq_n[1] = 1'b1; step(3);
        ext_irq_n[1] = 1'b0; step(4);
        chk("R3 after high", irq_pend[1], 1);
        ext_irq_n[1] = 1'b1; step(2);

        // R9: no wake while awake
        ext_irq_n[0] = 1'b0; step(1);
        chk("R9 awake no wake", wake_req, 0);
        ext_irq_n[0] = 1'b1; idle_stop = 1'b1; step(1);
        chk("R9 idle pins high", wake_req, 0);
        // R9: clock halted, short low pulse
        clk_run = 1'b0; #5;
        ext_irq_n[3] = 1'b0; #10; ext_irq_n[3] = 1'b1; #5;
        chk("R9 clockless set", wake_req, 1);
        clk_run = 1'b1; step(1);
        chk("R9 holds in idle", wake_req, 1);
        idle_stop = 1'b0; step(1);
        chk("R9 clears awake", wake_req, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule